// File: doc/BRIEF.md
# Clock-Embedding Five-Level Intensity Encoder

This block prepares the drive pattern for a single optical emitter that carries two serial data streams and their common clock over one fibre. Three channel enables switch resistor-weighted current branches; the emitter current is the sum of the branches that conduct, so the on/off pattern of the enables selects one of five intensity steps. The heaviest branch carries half of full scale and the two lighter branches a quarter each.

The clock is embedded in the light itself. In every low phase of the transmit clock all three enables are on, so the full-intensity step appears once per cycle whatever the data are. A receiver can track that step to set its decision thresholds and to recover the clock. In the high phase the two data bits, captured on the rising edge, select one of the four lower steps. The enables are formed by gates on the registered data and the clock, with no further register, so the intensity follows the clock phase directly. A 3-bit level index, counted in quarters of full scale, is exported so that the encoding can be checked without modelling currents.

Both data inputs are sampled on every rising edge. There is no valid/ready handshake and no back-pressure, because the optical link runs at a fixed rate and a new symbol is sent every clock cycle.

Top module: `imenc_tx`

## Requirements
- R1: A synchronous active-low reset clears both data registers. In the high phase after a rising edge that sees the reset asserted, `lane_en` is 3'b000 and `level_idx` is 0, whatever the data inputs are.
- R2: While `tx_clk` is low, `lane_en` is 3'b111 and `level_idx` is 4 (full intensity), whatever the data are.
- R3: While `tx_clk` is high and the captured bits (`din_a`,`din_b`) are (1,1), `lane_en` is 3'b110 and `level_idx` is 3.
- R4: While `tx_clk` is high and the captured bits are (1,0), `lane_en` is 3'b100 and `level_idx` is 2.
- R5: While `tx_clk` is high and the captured bits are (0,1), `lane_en` is 3'b010 and `level_idx` is 1.
- R6: While `tx_clk` is high and the captured bits are (0,0), `lane_en` is 3'b000 and `level_idx` is 0.
- R7: The data inputs are sampled only on the rising edge of `tx_clk`. A change to `din_a` or `din_b` during the high phase leaves the outputs unchanged until the next rising edge.
- R8: `level_idx` always equals the sum of the conducting branch weights, counted in quarters of full scale: bit 2 of `lane_en` weighs 2, bit 1 weighs 1 and bit 0 weighs 1.
- R9: Bit 0 of `lane_en` (the clock-only branch) is 1 exactly while `tx_clk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit clock. It samples the data and also selects the full-intensity phase |
| rst_n | input | 1 | Synchronous reset, active low |
| din_a | input | 1 | First serial data stream; drives the half-weight branch |
| din_b | input | 1 | Second serial data stream; drives a quarter-weight branch |
| lane_en | output | 3 | Branch enables: bit 2 is the half-weight branch, bits 1 and 0 are quarter-weight branches |
| level_idx | output | 3 | Intensity step in quarters of full scale (0 to 4) |

## Verification
On every rising edge the assertions check the value the outputs had during the preceding low phase, which must be the full-intensity pattern. On every falling edge they check the high-phase value: the enables must match the data sampled at the last rising edge, the clock-only branch must be off, the level index must agree with the branch weights, and a reset seen at the previous rising edge must leave the enables cleared. Only the bench scenarios show that data changed in the middle of a high phase are not seen until the next rising edge, and that each of the four data combinations gives its own step in turn.

// File: rtl/imenc_pkg.sv
package imenc_pkg;
  // Number of serial data lanes feeding the encoder.
  localparam int LANES = 2;
  // Number of weighted drive branches.
  localparam int NCH = 3;
  // Width of the exported level index.
  localparam int LVL_W = 3;
  // Branch weights in quarters of full scale, indexed by enable bit.
  localparam int unsigned CH_WEIGHT [NCH] = '{1, 1, 2};
  // Step index of the full-intensity (clock) phase.
  localparam int unsigned PEAK_LVL = 4;

  typedef logic [NCH-1:0]   chan_en_t;
  typedef logic [LANES-1:0] lane_bits_t;
  typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/imenc_capture.sv
// Registers the serial data lanes on the rising edge of the transmit clock.
module imenc_capture #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/imenc_pattern.sv
// Gates the captured lanes with the clock phase into branch enables.
// Low phase: every branch on. High phase: lane bits on the data branches,
// clock-only branch off.
module imenc_pattern
  import imenc_pkg::*;
(
  input  logic       clk,
  input  lane_bits_t bits,
  output chan_en_t   en
);
  logic low_phase;
  assign low_phase = ~clk;

  // bits[1] is lane a (half-weight branch), bits[0] is lane b.
  for (genvar c = 1; c < NCH; c++) begin : g_data_branch
    assign en[c] = bits[c-1] | low_phase;
  end
  assign en[0] = low_phase;
endmodule

// File: rtl/imenc_level.sv
// Sums the weights of the conducting branches into a step index.
module imenc_level
  import imenc_pkg::*;
(
  input  chan_en_t en,
  output level_t   level
);
  always_comb begin
    int unsigned acc;
    acc = 0;
    for (int c = 0; c < NCH; c++) begin
      if (en[c]) acc = acc + CH_WEIGHT[c];
    end
    level = LVL_W'(acc);
  end
endmodule

// File: rtl/imenc_tx.sv
module imenc_tx
  import imenc_pkg::*;
(
  input  logic             tx_clk,
  input  logic             rst_n,
  input  logic             din_a,
  input  logic             din_b,
  output logic [NCH-1:0]   lane_en,
  output logic [LVL_W-1:0] level_idx
);
  lane_bits_t cap_q;
  chan_en_t   en_w;
  level_t     lvl_w;

  imenc_capture #(.W(LANES)) u_capture (
    .clk   (tx_clk),
    .rst_n (rst_n),
    .d     ({din_a, din_b}),
    .q     (cap_q)
  );

  imenc_pattern u_pattern (
    .clk  (tx_clk),
    .bits (cap_q),
    .en   (en_w)
  );

  imenc_level u_level (
    .en    (en_w),
    .level (lvl_w)
  );

  assign lane_en   = en_w;
  assign level_idx = lvl_w;
endmodule

// File: rtl/imenc_chk.sv
module imenc_chk
  import imenc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             din_a,
  input logic             din_b,
  input logic [NCH-1:0]   lane_en,
  input logic [LVL_W-1:0] level_idx
);
  logic       rst_seen;
  lane_bits_t shadow;

  always_ff @(posedge clk) begin
    rst_seen <= !rst_n;
    if (!rst_n) shadow <= '0;
    else        shadow <= {din_a, din_b};
  end

  // R1: reset seen at a rising edge clears the high-phase pattern.
  a_r1_reset_clear: assert property (@(negedge clk)
    rst_seen |-> (lane_en == 3'b000 && level_idx == 3'd0));

  // R2: the values held through the low phase are the full-intensity step.
  a_r2_low_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en == 3'b111 && level_idx == 3'(PEAK_LVL)));

  // R7 (also R3, R4, R5, R6): high-phase data branches follow the bits sampled at the rising edge.
  a_r7_edge_capture: assert property (@(negedge clk) disable iff (!rst_n)
    lane_en[2:1] == shadow);

  // R8: the index agrees with the branch weights during the high phase.
  a_r8_level_weight: assert property (@(negedge clk) disable iff (!rst_n)
    level_idx == 3'(2 * lane_en[2] + lane_en[1] + lane_en[0]));

  // R9: the clock-only branch is off during the high phase.
  a_r9_clock_branch: assert property (@(negedge clk) disable iff (!rst_n)
    lane_en[0] == 1'b0);
endmodule

bind imenc_tx imenc_chk u_chk (
  .clk       (tx_clk),
  .rst_n     (rst_n),
  .din_a     (din_a),
  .din_b     (din_b),
  .lane_en   (lane_en),
  .level_idx (level_idx)
);

// File: tb/tb_imenc_tx.sv
`timescale 1ns/100ps
module tb_imenc_tx;
  logic       tx_clk = 1'b0;
  logic       rst_n  = 1'b0;
  logic       din_a  = 1'b1;
  logic       din_b  = 1'b1;
  logic [2:0] lane_en;
  logic [2:0] level_idx;
  int checks = 0;
  int errors = 0;

  imenc_tx dut (
    .tx_clk    (tx_clk),
    .rst_n     (rst_n),
    .din_a     (din_a),
    .din_b     (din_b),
    .lane_en   (lane_en),
    .level_idx (level_idx)
  );

  always #2 tx_clk = ~tx_clk;

  task automatic check(input string req, input logic [2:0] en_exp, input logic [2:0] lvl_exp);
    checks++;
    if (lane_en !== en_exp || level_idx !== lvl_exp) begin
      errors++;
      $display("FAIL %s: lane_en=%b level_idx=%0d expected lane_en=%b level_idx=%0d",
               req, lane_en, level_idx, en_exp, lvl_exp);
    end
  endtask

  // Expected high-phase pattern from the requirement table.
  function automatic logic [2:0] exp_en(input logic a, input logic b);
    return {a, b, 1'b0};
  endfunction

  function automatic logic [2:0] exp_lvl(input logic a, input logic b);
    return 3'(2 * a + b);
  endfunction

  function automatic string req_of(input logic a, input logic b);
    case ({a, b})
      2'b11:   return "R3";
      2'b10:   return "R4";
      2'b01:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Drive a symbol in the low phase; check its high phase and the next low phase.
  task automatic send(input logic a, input logic b);
    @(negedge tx_clk);
    din_a = a;
    din_b = b;
    @(posedge tx_clk); #1;
    check(req_of(a, b), exp_en(a, b), exp_lvl(a, b));
    @(negedge tx_clk); #1;
    check("R2", 3'b111, 3'd4);
  endtask

  task automatic t_reset;
    // din is 1,1 while reset is held: R1 requires a cleared pattern anyway.
    @(posedge tx_clk); @(posedge tx_clk); #1;
    check("R1", 3'b000, 3'd0);
    @(negedge tx_clk); #1;
    check("R2", 3'b111, 3'd4);
    rst_n = 1'b1;
  endtask

  task automatic t_each_level;
    send(1'b1, 1'b1);
    send(1'b1, 1'b0);
    send(1'b0, 1'b1);
    send(1'b0, 1'b0);
  endtask

  task automatic t_low_phase_ignores_data;
    for (int v = 0; v < 4; v++) begin
      @(negedge tx_clk); #0.5;
      din_a = v[1];
      din_b = v[0];
      #0.5;
      check("R2", 3'b111, 3'd4);
    end
  endtask

  task automatic t_midcycle_change;
    send(1'b1, 1'b0);
    @(negedge tx_clk);
    din_a = 1'b0; din_b = 1'b1;
    @(posedge tx_clk); #0.5;
    din_a = 1'b1; din_b = 1'b1;   // changed while clock is high
    #1;
    check("R7", 3'b010, 3'd1);
    @(posedge tx_clk); #1;
    check("R7", 3'b110, 3'd3);
  endtask

  task automatic t_reset_midstream;
    send(1'b1, 1'b1);
    @(negedge tx_clk);
    rst_n = 1'b0;
    @(posedge tx_clk); #1;
    check("R1", 3'b000, 3'd0);
    @(negedge tx_clk);
    rst_n = 1'b1;
  endtask

  task automatic t_weight_sequence;
    // R8 and R9: walk a mixed bit sequence, checking index and clock branch.
    logic [7:0] pa = 8'b1011_0010;
    logic [7:0] pb = 8'b0110_1100;
    for (int i = 0; i < 8; i++) begin
      @(negedge tx_clk);
      din_a = pa[i]; din_b = pb[i];
      @(posedge tx_clk); #1;
      check("R8", exp_en(pa[i], pb[i]), exp_lvl(pa[i], pb[i]));
      checks++;
      if (lane_en[0] !== 1'b0) begin
        errors++;
        $display("FAIL R9: high-phase lane_en[0]=%b expected 0", lane_en[0]);
      end
      @(negedge tx_clk); #1;
      checks++;
      if (lane_en[0] !== 1'b1) begin
        errors++;
        $display("FAIL R9: low-phase lane_en[0]=%b expected 1", lane_en[0]);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_each_level();
    t_low_phase_ignores_data();
    t_midcycle_change();
    t_reset_midstream();
    t_weight_sequence();
    t_each_level();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule